// File: doc/BRIEF.md
# Banked Configurable GPIO Port Controller

This block is a byte-wide general-purpose I/O controller that sits behind a small parallel register bus. The bus has an address, write data, read data, a write strobe and a read strobe. Several 8-bit I/O ports occupy the low offsets. The offset just above them holds an auxiliary register pair, and the top offset holds a control word. The two most significant bits of the control word form a bank field. That field picks which of four registers answers at every port offset: the data register, the polarity setup, the read-source setup or the latch-mode setup.

Each port bit has its own output polarity and chooses between a latched and an unlatched input. It also selects what a read returns. An unlatched bit returns either its pin or the value last written. A latched bit returns either the raw captured value or that byte after Gray-to-binary conversion. A strobe input captures all port pins at once. Software normally sets the bank field only while configuring, then clears it to 00 so that the port offsets give data access again.

Pins are modelled as an open-drain drive-low enable vector plus a pin-level input vector. A bench can therefore loop the pins back or force their levels.

Top module: `banked_gpio`

## Requirements
- R1: After reset, every data, setup and latch register and the control word hold 0. As a result every drive_low bit is 1, and reading the control word offset (7) returns 0x00.
- R2: Bits 7:6 of the control word select the bank at port offsets 0 to 5: 00 data, 01 polarity, 10 read source, 11 latch mode. Writes and reads reach only the register of the selected bank. The other three registers at that offset keep their values.
- R3: When a polarity bit is 0, the output is inverting: a written 0 sets drive_low to 1 and a written 1 sets drive_low to 0.
- R4: When a polarity bit is 1, the output is non-inverting: a written 1 sets drive_low to 1 and a written 0 sets drive_low to 0.
- R5: The input level is corrected by the polarity bit before any source is chosen. With polarity 0 a low pin reads 1; with polarity 1 a low pin reads 0. With latch-mode 0 and read-source 0, a data read returns this corrected pin value.
- R6: With latch-mode 0 and read-source 1, a data read returns the last value written to the data register. The choice is made bit by bit.
- R7: A rising edge on latch_strobe captures the corrected pins of every port into that port's latch register. The latch holds its value through pin changes until the next rising edge.
- R8: With latch-mode 1 and read-source 0, a data read returns the raw latched bit.
- R9: With latch-mode 1 and read-source 1, a data read returns the bit of the Gray-to-binary conversion of the whole latched byte. Binary bit i is the XOR of latched bits 7 down to i.
- R10: Offset 6 returns its data register in bank 00. Banks 01 and 10 both reach one shared setup register there. In bank 11, reads return 0x00 and writes change nothing.
- R11: A read strobe in one cycle gives rd_valid high and the addressed value on rd_data in the next cycle. rd_valid stays low when no read was requested.
- R12: Offset 7 always accesses the control word, whatever the bank field holds. A write there is returned unchanged by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BYTE_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | BYTE_W | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| latch_strobe | input | 1 | Rising edge captures all port pins |
| pin_in | input | NUM_PORTS*BYTE_W | Pin levels, port p at bits p*BYTE_W and up |
| drive_low | output | NUM_PORTS*BYTE_W | 1 pulls the matching pin low |

## Verification
The hardest state to reach from the ports is a latched port that holds an old capture while its pins already show different levels, read through a per-bit mix of raw and Gray-decoded sources. Reaching it takes a fixed order of steps. The stimulus first uses the banked setup offsets to make the port non-inverting and latched. It then pulses the strobe against one pin pattern and walks the read-source register through all-raw, all-decoded and half-and-half settings. Finally it changes the pins without a strobe and confirms that the old capture is still read before the next strobe replaces it. Inverting ports, mixed pin/written-value reads and the offset-6 bank 11 hole are covered with the same driver and scoreboard.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;

   // Bank field values; the encoding is decoded by every port and the aux pair
   typedef enum logic [1:0] {
      BANK_DATA  = 2'b00,
      BANK_POL   = 2'b01,
      BANK_RSRC  = 2'b10,
      BANK_LATCH = 2'b11
   } bank_e;

endpackage

// File: rtl/bgpio_gray_dec.sv
module bgpio_gray_dec #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] gray_i,
   output logic [WIDTH-1:0] bin_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bgpio_gray_dec: WIDTH must be at least 1");
   end

   // Each binary bit folds in every Gray bit at or above its own position
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[WIDTH-1:i];
   end

endmodule

// File: rtl/bgpio_port.sv
module bgpio_port
   import banked_gpio_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit GRAY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  bank_e            bank,
   input  logic [WIDTH-1:0] wdata,
   input  logic             capture,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] drive_low,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] pol_q;
   logic [WIDTH-1:0] rsrc_q;
   logic [WIDTH-1:0] lmode_q;
   logic [WIDTH-1:0] cap_q;
   logic [WIDTH-1:0] pin_corr;
   logic [WIDTH-1:0] gray_bin;
   logic [WIDTH-1:0] data_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         pol_q   <= '0;
         rsrc_q  <= '0;
         lmode_q <= '0;
      end else if (sel_wr) begin
         unique case (bank)
            BANK_DATA:  data_q  <= wdata;
            BANK_POL:   pol_q   <= wdata;
            BANK_RSRC:  rsrc_q  <= wdata;
            BANK_LATCH: lmode_q <= wdata;
            default:    data_q  <= data_q;
         endcase
      end
   end

   // Polarity bit 0 means inverting in both directions
   assign pin_corr  = ~(pin_in ^ pol_q);
   assign drive_low = ~(data_q ^ pol_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q <= '0;
      else if (capture) cap_q <= pin_corr;
   end

   if (GRAY_EN) begin : g_gray
      bgpio_gray_dec #(.WIDTH(WIDTH)) u_gray (
         .gray_i (cap_q),
         .bin_o  (gray_bin)
      );
   end else begin : g_no_gray
      assign gray_bin = cap_q;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_src
      always_comb begin
         unique case ({lmode_q[i], rsrc_q[i]})
            2'b00:   data_view[i] = pin_corr[i];
            2'b01:   data_view[i] = data_q[i];
            2'b10:   data_view[i] = cap_q[i];
            default: data_view[i] = gray_bin[i];
         endcase
      end
   end

   always_comb begin
      unique case (bank)
         BANK_DATA:  rdata = data_view;
         BANK_POL:   rdata = pol_q;
         BANK_RSRC:  rdata = rsrc_q;
         default:    rdata = lmode_q;
      endcase
   end

   // R7: a capture loads the corrected pins, otherwise the latch is frozen
   p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> cap_q == $past(pin_corr));
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(cap_q));
   // R3: a data write shows up on the pins through the current polarity
   p_drive_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && bank == BANK_DATA) |=> drive_low == ~($past(wdata) ^ pol_q));
   // R2: polarity setup moves only on a write in its own bank
   p_pol_bank_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_wr && bank == BANK_POL) |=> $stable(pol_q));

endmodule

// File: rtl/bgpio_aux.sv
module bgpio_aux
   import banked_gpio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  bank_e            bank,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         setup_q <= '0;
      end else if (sel_wr) begin
         unique case (bank)
            BANK_DATA:           data_q  <= wdata;
            BANK_POL, BANK_RSRC: setup_q <= wdata;
            default:             data_q  <= data_q;
         endcase
      end
   end

   always_comb begin
      unique case (bank)
         BANK_DATA:           rdata = data_q;
         BANK_POL, BANK_RSRC: rdata = setup_q;
         default:             rdata = '0;
      endcase
   end

   // R10: a write in the empty bank leaves both registers untouched
   p_aux_hole_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && bank == BANK_LATCH) |=> ($stable(data_q) && $stable(setup_q)));
   always_comb begin
      if (rst_n && bank == BANK_LATCH)
         p_aux_hole_reads_zero_r10: assert (rdata == '0);
   end

endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
   import banked_gpio_pkg::*;
#(
   parameter int NUM_PORTS = 6,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit GRAY_EN   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic [BYTE_W-1:0]           wr_data,
   input  logic                        rd_en,
   output logic [BYTE_W-1:0]           rd_data,
   output logic                        rd_valid,
   input  logic                        latch_strobe,
   input  logic [NUM_PORTS*BYTE_W-1:0] pin_in,
   output logic [NUM_PORTS*BYTE_W-1:0] drive_low
);

   localparam int AUX_OFS  = NUM_PORTS;
   localparam int CTRL_OFS = NUM_PORTS + 1;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("banked_gpio: BYTE_W must hold the two-bit bank field");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("banked_gpio: NUM_PORTS must be at least 1");
   end
   if ((1 << ADDR_W) < NUM_PORTS + 2) begin : g_bad_addr
      $error("banked_gpio: ADDR_W too narrow for ports plus aux and control");
   end

   logic [BYTE_W-1:0] ctrl_q;
   bank_e             bank;
   logic              strobe_q;
   logic              capture;
   logic [BYTE_W-1:0] port_rd [NUM_PORTS];
   logic [BYTE_W-1:0] aux_rd;
   logic [BYTE_W-1:0] rd_next;
   logic              ctrl_sel;
   logic              aux_sel;

   assign bank     = bank_e'(ctrl_q[BYTE_W-1 -: 2]);
   assign ctrl_sel = wr_en && (addr == ADDR_W'(CTRL_OFS));
   assign aux_sel  = wr_en && (addr == ADDR_W'(AUX_OFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (ctrl_sel) ctrl_q <= wr_data;
   end

   // Rising-edge detect on the capture strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= latch_strobe;
   end
   assign capture = latch_strobe && !strobe_q;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      bgpio_port #(
         .WIDTH   (BYTE_W),
         .GRAY_EN (GRAY_EN)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_wr    (wr_en && (addr == ADDR_W'(p))),
         .bank      (bank),
         .wdata     (wr_data),
         .capture   (capture),
         .pin_in    (pin_in[p*BYTE_W +: BYTE_W]),
         .drive_low (drive_low[p*BYTE_W +: BYTE_W]),
         .rdata     (port_rd[p])
      );
   end

   bgpio_aux #(.WIDTH(BYTE_W)) u_aux (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_wr (aux_sel),
      .bank   (bank),
      .wdata  (wr_data),
      .rdata  (aux_rd)
   );

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr == ADDR_W'(p)) rd_next = port_rd[p];
      end
      if (addr == ADDR_W'(AUX_OFS))  rd_next = aux_rd;
      if (addr == ADDR_W'(CTRL_OFS)) rd_next = ctrl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_next;
      end
   end

   // R11: one-cycle read response
   p_rd_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_rd_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   // R12: control word takes the written byte whatever the bank
   p_ctrl_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(CTRL_OFS)) |=> ctrl_q == $past(wr_data));
   // R12: a control read returns the control word
   p_ctrl_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(CTRL_OFS) && !wr_en) |=> rd_data == $past(ctrl_q));

endmodule

// File: tb/tb_banked_gpio.sv
module tb_banked_gpio;

   localparam int NP = 6;
   localparam int BW = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [BW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [BW-1:0] rd_data;
   logic          rd_valid;
   logic          latch_strobe = 1'b0;
   logic [NP*BW-1:0] pin_in = '1;
   logic [NP*BW-1:0] drive_low;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [BW-1:0] exp_q [$];
   string         tag_q [$];

   always #5 clk = ~clk;

   banked_gpio #(.NUM_PORTS(NP), .BYTE_W(BW), .ADDR_W(AW), .GRAY_EN(1'b1)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (addr),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid),
      .latch_strobe (latch_strobe),
      .pin_in       (pin_in),
      .drive_low    (drive_low)
   );

   task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [BW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input logic [BW-1:0] exp, input string tag);
      @(negedge clk);
      addr = AW'(a); rd_en = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_bank(input logic [1:0] b);
      wr(7, {b, 6'b0});
   endtask

   task automatic strobe();
      @(negedge clk); latch_strobe = 1'b1;
      @(negedge clk); @(negedge clk); latch_strobe = 1'b0;
   endtask

   // Monitor: pops the scoreboard whenever a read result appears
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11: got unexpected rd_valid, data %h expected no response", rd_data);
         end else begin
            logic [BW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rd_data, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int p = 0; p < NP; p++) check("R1 drive_low", drive_low[p*BW +: BW], 8'hFF);
      rd(7, 8'h00, "R1 ctrl");
      rd(0, 8'h00, "R1 port0 pin view");

      // R12 / R2: bank select and control readback
      set_bank(2'b01);
      rd(7, 8'h40, "R12 ctrl readback");
      wr(0, 8'hF0);
      set_bank(2'b00);
      wr(0, 8'hA5);
      @(negedge clk);
      check("R4 mixed polarity drive", drive_low[0 +: BW], 8'hAA);
      wr(1, 8'h3C);
      @(negedge clk);
      check("R3 inverting drive", drive_low[BW +: BW], 8'hC3);

      // R5: corrected pin view
      pin_in[0 +: BW] = 8'h36;
      rd(0, 8'h39, "R5 pin view");

      // R6: written value view, full and per-bit
      set_bank(2'b10);
      wr(0, 8'hFF);
      rd(0, 8'hFF, "R2 rsrc bank read");
      set_bank(2'b00);
      rd(0, 8'hA5, "R6 written view");
      set_bank(2'b10);
      wr(0, 8'h0F);
      set_bank(2'b00);
      rd(0, 8'h35, "R6 per-bit mix");

      // R2: untouched banks keep their values
      set_bank(2'b11);
      rd(0, 8'h00, "R2 latch bank untouched");
      set_bank(2'b01);
      rd(0, 8'hF0, "R2 pol bank kept");

      // R7/R8/R9: latched port 2, non-inverting
      wr(2, 8'hFF);
      set_bank(2'b11);
      wr(2, 8'hFF);
      set_bank(2'b00);
      pin_in[2*BW +: BW] = 8'hB4;
      strobe();
      rd(2, 8'hB4, "R8 raw latch");
      set_bank(2'b10);
      wr(2, 8'hFF);
      set_bank(2'b00);
      rd(2, 8'hD8, "R9 gray decode");
      set_bank(2'b10);
      wr(2, 8'h0F);
      set_bank(2'b00);
      rd(2, 8'hB8, "R9 per-bit gray mix");
      set_bank(2'b10);
      wr(2, 8'h00);
      set_bank(2'b00);
      pin_in[2*BW +: BW] = 8'h11;
      repeat (3) @(negedge clk);
      rd(2, 8'hB4, "R7 hold without strobe");
      strobe();
      rd(2, 8'h11, "R7 new capture");

      // R10: offset 6 pair
      wr(6, 8'h5A);
      set_bank(2'b01);
      wr(6, 8'h77);
      set_bank(2'b10);
      rd(6, 8'h77, "R10 shared setup");
      set_bank(2'b11);
      wr(6, 8'h99);
      rd(6, 8'h00, "R10 hole reads zero");
      set_bank(2'b01);
      rd(6, 8'h77, "R10 setup unchanged");
      set_bank(2'b00);
      rd(6, 8'h5A, "R10 data unchanged");

      // R11: idle bus gives no response
      repeat (2) @(negedge clk);
      check("R11 idle rd_valid", {7'b0, rd_valid}, 8'h00);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R11: got %0d pending reads expected 0", exp_q.size());
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule